// File: doc/BRIEF.md
# Interlaced Digital Video Raster Timing Generator

This block produces the raster timing for an interlaced digital component video output (ITU-R BT.656 style, or separate luma/chroma). It runs a frame line counter and a frame pixel counter. From them it derives three flags: a horizontal blanking flag (H), a vertical blanking flag (V) and a field flag (F). Every edge of horizontal blanking triggers a four-word timing reference code. The code carries the current F, V and H values, so a downstream multiplexer can place it in the output word stream.

Every raster dimension and every transition point comes from configuration inputs, not from a fixed line table. These are the frame size, the pixel positions where horizontal blanking starts and stops, and separate V set and clear lines for each field. The F clear and F set lines are also configuration inputs. Configuration is copied into shadow registers while the generator is disabled and at each frame wrap. A change made mid-frame therefore never tears the current raster.

The code inserter is a small state machine with five states:
- `TRS_IDLE`: no code in progress.
- `TRS_PRE0`: drives the word 0xFF.
- `TRS_PRE1`: drives the first 0x00 word.
- `TRS_PRE2`: drives the second 0x00 word.
- `TRS_XY`: drives the status word.

Its transitions are:
- *start*: IDLE to PRE0 when enabled and the pixel counter sits on a blanking start or stop position.
- *advance*: PRE0 to PRE1 to PRE2 to XY, one step per clock.
- *finish*: XY to IDLE.
- *abort*: any state to IDLE when the enable drops.

Top module: `vid_raster_gen`

## Requirements
- R1: While enabled, the pixel counter steps by one per clock from 0 up to the configured width minus one and then returns to 0. On that return the line counter steps by one, and it returns to 1 after the configured height.
- R2: H becomes 1 on the clock after the pixel counter equals the blanking start value. It becomes 0 on the clock after the counter equals the blanking stop value. Start wins if the two values are equal.
- R3: For field 1, V becomes 1 when a line equal to the field 1 set value begins and 0 when a line equal to the field 1 clear value begins. The new value is visible from pixel 1 of that line.
- R4: For field 2, V is set and cleared in the same way at its own independent set line and clear line.
- R5: F becomes 0 at the start of the configured F clear line and 1 at the start of the configured F set line. The new value is visible from pixel 1 of that line.
- R6: When the pixel counter equals the blanking start or stop value, `trs_valid` is 1 for the next four clocks. During those clocks `trs_data` carries 0xFF, 0x00, 0x00 and then the status word. Outside a code, `trs_valid` is 0 and `trs_data` is 0x00.
- R7: The status word holds these bits:
  - bit 7: 1.
  - bit 6: F.
  - bit 5: V.
  - bit 4: H, which is 1 for a code at blanking start (end of active video) and 0 for a code at blanking stop (start of active video).
  - bit 3: V xor H.
  - bit 2: F xor H.
  - bit 1: F xor V.
  - bit 0: F xor V xor H.
- R8: While `en` is 0, one clock brings the line counter to 1, the pixel counter to 0, and H, V, F, `trs_valid` and `trs_data` to 0. A code in progress is dropped.
- R9: A configuration change made while enabled has no effect until the frame wrap from the last pixel of the last line. From that wrap on, the new values apply.
- R10: The F and V bits of a status word are the values that apply on the line where the code is emitted, including a change that takes effect at the start of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Run enable; low holds the raster at its start |
| cfg_lines | input | LW | Lines per frame |
| cfg_pixels | input | PW | Pixels per line |
| cfg_hblank_on | input | PW | Pixel position where H is raised |
| cfg_hblank_off | input | PW | Pixel position where H is dropped |
| cfg_vf1_on | input | LW | Field 1 line that sets V |
| cfg_vf1_off | input | LW | Field 1 line that clears V |
| cfg_vf2_on | input | LW | Field 2 line that sets V |
| cfg_vf2_off | input | LW | Field 2 line that clears V |
| cfg_fld_lo | input | LW | Line where F is cleared |
| cfg_fld_hi | input | LW | Line where F is set |
| line_cnt | output | LW | Frame line counter (1-based) |
| pix_cnt | output | PW | Frame pixel counter (0-based) |
| h_flag | output | 1 | Horizontal blanking flag |
| v_flag | output | 1 | Vertical blanking flag |
| f_flag | output | 1 | Field flag |
| trs_valid | output | 1 | High while a timing reference word is driven |
| trs_data | output | 8 | Timing reference word |

## Verification
The hardest situation to reach from the ports is a configuration change landing mid-frame. The bench widens the line in the middle of the second line. It then counts clocks to show that the rest of that frame still wraps at the old width and that the next frame uses the new one. A second hard case is a status word emitted on a line whose first pixel just changed V and F. The small raster is set so that blanking stop falls three pixels into such lines. Its codes must therefore report the values just applied. The bench also drops the enable in the middle of a status word to check that the code is abandoned.

// File: rtl/vid_raster_pkg.sv
package vid_raster_pkg;

    typedef enum logic [2:0] {
        TRS_IDLE = 3'd0,
        TRS_PRE0 = 3'd1,
        TRS_PRE1 = 3'd2,
        TRS_PRE2 = 3'd3,
        TRS_XY   = 3'd4
    } trs_state_t;

    localparam logic [7:0] TRS_WORD_FF = 8'hFF;
    localparam logic [7:0] TRS_WORD_00 = 8'h00;

    // status word: 1 F V H, then protection bits
    function automatic logic [7:0] trs_status(input logic f, input logic v, input logic h);
        trs_status = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/vid_raster_cnt.sv
module vid_raster_cnt #(
    parameter int LW = 11,
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [LW-1:0] cfg_lines,
    input  logic [PW-1:0] cfg_pixels,
    input  logic [PW-1:0] cfg_hblank_on,
    input  logic [PW-1:0] cfg_hblank_off,
    input  logic [LW-1:0] cfg_vf1_on,
    input  logic [LW-1:0] cfg_vf1_off,
    input  logic [LW-1:0] cfg_vf2_on,
    input  logic [LW-1:0] cfg_vf2_off,
    input  logic [LW-1:0] cfg_fld_lo,
    input  logic [LW-1:0] cfg_fld_hi,
    output logic [LW-1:0] line_q,
    output logic [PW-1:0] pix_q,
    output logic [PW-1:0] s_hon,
    output logic [PW-1:0] s_hoff,
    output logic [LW-1:0] s_v1on,
    output logic [LW-1:0] s_v1off,
    output logic [LW-1:0] s_v2on,
    output logic [LW-1:0] s_v2off,
    output logic [LW-1:0] s_flo,
    output logic [LW-1:0] s_fhi
);

    localparam logic [LW-1:0] LINE_FIRST = LW'(1);
    localparam logic [PW-1:0] PIX_ONE    = PW'(1);

    logic [LW-1:0] s_lines;
    logic [PW-1:0] s_pixels;
    logic          line_end;
    logic          frame_end;

    assign line_end  = (pix_q == s_pixels - PIX_ONE);
    assign frame_end = line_end && (line_q == s_lines);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q   <= LINE_FIRST;
            pix_q    <= '0;
            s_lines  <= '0;
            s_pixels <= '0;
            s_hon    <= '0;
            s_hoff   <= '0;
            s_v1on   <= '0;
            s_v1off  <= '0;
            s_v2on   <= '0;
            s_v2off  <= '0;
            s_flo    <= '0;
            s_fhi    <= '0;
        end else begin
            if (!en || frame_end) begin
                s_lines  <= cfg_lines;
                s_pixels <= cfg_pixels;
                s_hon    <= cfg_hblank_on;
                s_hoff   <= cfg_hblank_off;
                s_v1on   <= cfg_vf1_on;
                s_v1off  <= cfg_vf1_off;
                s_v2on   <= cfg_vf2_on;
                s_v2off  <= cfg_vf2_off;
                s_flo    <= cfg_fld_lo;
                s_fhi    <= cfg_fld_hi;
            end
            if (!en) begin
                line_q <= LINE_FIRST;
                pix_q  <= '0;
            end else if (line_end) begin
                pix_q  <= '0;
                line_q <= frame_end ? LINE_FIRST : line_q + LINE_FIRST;
            end else begin
                pix_q  <= pix_q + PIX_ONE;
            end
        end
    end

    // R1
    line_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_q != '0);

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && frame_end) |=> (line_q == LINE_FIRST && pix_q == '0));

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !frame_end) |=> ($stable(s_pixels) && $stable(s_lines)));

endmodule

// File: rtl/vid_raster_flags.sv
module vid_raster_flags #(
    parameter int LW = 11,
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [LW-1:0] line_q,
    input  logic [PW-1:0] pix_q,
    input  logic [PW-1:0] s_hon,
    input  logic [PW-1:0] s_hoff,
    input  logic [LW-1:0] s_v1on,
    input  logic [LW-1:0] s_v1off,
    input  logic [LW-1:0] s_v2on,
    input  logic [LW-1:0] s_v2off,
    input  logic [LW-1:0] s_flo,
    input  logic [LW-1:0] s_fhi,
    output logic          h_q,
    output logic          v_q,
    output logic          f_q,
    output logic          v_nxt,
    output logic          f_nxt,
    output logic          eav_go,
    output logic          sav_go
);

    logic line_begin;
    logic h_nxt;

    assign line_begin = (pix_q == '0);
    assign eav_go     = (pix_q == s_hon);
    assign sav_go     = (pix_q == s_hoff) && !eav_go;

    always_comb begin
        h_nxt = h_q;
        if (eav_go)      h_nxt = 1'b1;
        else if (sav_go) h_nxt = 1'b0;

        v_nxt = v_q;
        if (line_begin) begin
            if (line_q == s_v1on || line_q == s_v2on)        v_nxt = 1'b1;
            else if (line_q == s_v1off || line_q == s_v2off) v_nxt = 1'b0;
        end

        f_nxt = f_q;
        if (line_begin) begin
            if (line_q == s_fhi)      f_nxt = 1'b1;
            else if (line_q == s_flo) f_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= 1'b0;
            v_q <= 1'b0;
            f_q <= 1'b0;
        end else if (!en) begin
            h_q <= 1'b0;
            v_q <= 1'b0;
            f_q <= 1'b0;
        end else begin
            h_q <= h_nxt;
            v_q <= v_nxt;
            f_q <= f_nxt;
        end
    end

    // R8
    flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!h_q && !v_q && !f_q));

    // R2
    h_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pix_q == s_hon) |=> h_q);

endmodule

// File: rtl/vid_raster_trs.sv
module vid_raster_trs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       eav_go,
    input  logic       sav_go,
    input  logic       v_nxt,
    input  logic       f_nxt,
    output logic       trs_valid,
    output logic [7:0] trs_data
);
    import vid_raster_pkg::*;

    trs_state_t state_q, state_d;
    logic [7:0] xy_q;

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = TRS_IDLE;
        end else begin
            unique case (state_q)
                TRS_IDLE: if (eav_go || sav_go) state_d = TRS_PRE0;
                TRS_PRE0: state_d = TRS_PRE1;
                TRS_PRE1: state_d = TRS_PRE2;
                TRS_PRE2: state_d = TRS_XY;
                TRS_XY:   state_d = TRS_IDLE;
                default:  state_d = TRS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRS_IDLE;
            xy_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TRS_IDLE && state_d == TRS_PRE0)
                xy_q <= trs_status(f_nxt, v_nxt, eav_go);
        end
    end

    always_comb begin
        trs_valid = 1'b1;
        trs_data  = TRS_WORD_00;
        unique case (state_q)
            TRS_IDLE: trs_valid = 1'b0;
            TRS_PRE0: trs_data  = TRS_WORD_FF;
            TRS_PRE1: trs_data  = TRS_WORD_00;
            TRS_PRE2: trs_data  = TRS_WORD_00;
            TRS_XY:   trs_data  = xy_q;
            default:  trs_valid = 1'b0;
        endcase
    end

    // R6
    trs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && trs_valid && trs_data == TRS_WORD_FF) |=> (trs_valid && trs_data == TRS_WORD_00));

    // R8
    trs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !trs_valid);

endmodule

// File: rtl/vid_raster_gen.sv
module vid_raster_gen #(
    parameter int LW = 11,
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [LW-1:0] cfg_lines,
    input  logic [PW-1:0] cfg_pixels,
    input  logic [PW-1:0] cfg_hblank_on,
    input  logic [PW-1:0] cfg_hblank_off,
    input  logic [LW-1:0] cfg_vf1_on,
    input  logic [LW-1:0] cfg_vf1_off,
    input  logic [LW-1:0] cfg_vf2_on,
    input  logic [LW-1:0] cfg_vf2_off,
    input  logic [LW-1:0] cfg_fld_lo,
    input  logic [LW-1:0] cfg_fld_hi,
    output logic [LW-1:0] line_cnt,
    output logic [PW-1:0] pix_cnt,
    output logic          h_flag,
    output logic          v_flag,
    output logic          f_flag,
    output logic          trs_valid,
    output logic [7:0]    trs_data
);

    logic [PW-1:0] s_hon, s_hoff;
    logic [LW-1:0] s_v1on, s_v1off, s_v2on, s_v2off, s_flo, s_fhi;
    logic          v_nxt, f_nxt, eav_go, sav_go;

    vid_raster_cnt #(.LW(LW), .PW(PW)) u_cnt (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .cfg_lines      (cfg_lines),
        .cfg_pixels     (cfg_pixels),
        .cfg_hblank_on  (cfg_hblank_on),
        .cfg_hblank_off (cfg_hblank_off),
        .cfg_vf1_on     (cfg_vf1_on),
        .cfg_vf1_off    (cfg_vf1_off),
        .cfg_vf2_on     (cfg_vf2_on),
        .cfg_vf2_off    (cfg_vf2_off),
        .cfg_fld_lo     (cfg_fld_lo),
        .cfg_fld_hi     (cfg_fld_hi),
        .line_q         (line_cnt),
        .pix_q          (pix_cnt),
        .s_hon          (s_hon),
        .s_hoff         (s_hoff),
        .s_v1on         (s_v1on),
        .s_v1off        (s_v1off),
        .s_v2on         (s_v2on),
        .s_v2off        (s_v2off),
        .s_flo          (s_flo),
        .s_fhi          (s_fhi)
    );

    vid_raster_flags #(.LW(LW), .PW(PW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .line_q  (line_cnt),
        .pix_q   (pix_cnt),
        .s_hon   (s_hon),
        .s_hoff  (s_hoff),
        .s_v1on  (s_v1on),
        .s_v1off (s_v1off),
        .s_v2on  (s_v2on),
        .s_v2off (s_v2off),
        .s_flo   (s_flo),
        .s_fhi   (s_fhi),
        .h_q     (h_flag),
        .v_q     (v_flag),
        .f_q     (f_flag),
        .v_nxt   (v_nxt),
        .f_nxt   (f_nxt),
        .eav_go  (eav_go),
        .sav_go  (sav_go)
    );

    vid_raster_trs u_trs (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .eav_go    (eav_go),
        .sav_go    (sav_go),
        .v_nxt     (v_nxt),
        .f_nxt     (f_nxt),
        .trs_valid (trs_valid),
        .trs_data  (trs_data)
    );

endmodule

// File: tb/vid_raster_gen_bench.sv
`timescale 1ns/1ps
module vid_raster_gen_bench;

    localparam int LW = 11;
    localparam int PW = 12;
    localparam int W  = 16;
    localparam int HT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [LW-1:0] cfg_lines, cfg_vf1_on, cfg_vf1_off, cfg_vf2_on, cfg_vf2_off, cfg_fld_lo, cfg_fld_hi;
    logic [PW-1:0] cfg_pixels, cfg_hblank_on, cfg_hblank_off;
    logic [LW-1:0] line_cnt;
    logic [PW-1:0] pix_cnt;
    logic          h_flag, v_flag, f_flag, trs_valid;
    logic [7:0]    trs_data;

    always #2.5 clk = ~clk;

    vid_raster_gen #(.LW(LW), .PW(PW)) u_vid_raster_gen (
        .clk(clk), .rst_n(rst_n), .en(en),
        .cfg_lines(cfg_lines), .cfg_pixels(cfg_pixels),
        .cfg_hblank_on(cfg_hblank_on), .cfg_hblank_off(cfg_hblank_off),
        .cfg_vf1_on(cfg_vf1_on), .cfg_vf1_off(cfg_vf1_off),
        .cfg_vf2_on(cfg_vf2_on), .cfg_vf2_off(cfg_vf2_off),
        .cfg_fld_lo(cfg_fld_lo), .cfg_fld_hi(cfg_fld_hi),
        .line_cnt(line_cnt), .pix_cnt(pix_cnt),
        .h_flag(h_flag), .v_flag(v_flag), .f_flag(f_flag),
        .trs_valid(trs_valid), .trs_data(trs_data)
    );

    int n_total = 0;
    int n_pass  = 0;
    int cur     = 0;
    bit done    = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_total++;
        if (act == exp) n_pass++;
        else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    // advance to enabled-clock index k, sample at the falling edge
    task automatic go_to(input int k);
        repeat (k - cur) @(posedge clk);
        @(negedge clk);
        cur = k;
    endtask

    typedef struct packed {
        bit [1:0] frame;
        bit [3:0] line;
        bit [4:0] pix;
        bit       h;
        bit       v;
        bit       f;
        bit       val;
        bit [7:0] data;
    } vec_t;

    // Raster: 8 lines x 16 px, H on at 10 / off at 2,
    // V field1 1..3, field2 5..7, F clear line 1, set line 5
    localparam vec_t VECS [10] = '{
        '{2'd0, 4'd1, 5'd6,  1'b0, 1'b1, 1'b0, 1'b1, 8'hAB},
        '{2'd0, 4'd1, 5'd12, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00},
        '{2'd0, 4'd2, 5'd14, 1'b1, 1'b1, 1'b0, 1'b1, 8'hB6},
        '{2'd0, 4'd3, 5'd11, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF},
        '{2'd0, 4'd3, 5'd14, 1'b1, 1'b0, 1'b0, 1'b1, 8'h9D},
        '{2'd0, 4'd5, 5'd6,  1'b0, 1'b1, 1'b1, 1'b1, 8'hEC},
        '{2'd0, 4'd5, 5'd14, 1'b1, 1'b1, 1'b1, 1'b1, 8'hF1},
        '{2'd0, 4'd7, 5'd8,  1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
        '{2'd0, 4'd8, 5'd14, 1'b1, 1'b0, 1'b1, 1'b1, 8'hDA},
        '{2'd1, 4'd1, 5'd6,  1'b0, 1'b1, 1'b0, 1'b1, 8'hAB}
    };

    task automatic chk_idle(input string req);
        chk(req, "line", int'(line_cnt), 1);
        chk(req, "pix", int'(pix_cnt), 0);
        chk(req, "h", int'(h_flag), 0);
        chk(req, "v", int'(v_flag), 0);
        chk(req, "f", int'(f_flag), 0);
        chk(req, "valid", int'(trs_valid), 0);
        chk(req, "data", int'(trs_data), 0);
    endtask

    initial begin
        cfg_lines = LW'(HT);  cfg_pixels = PW'(W);
        cfg_hblank_on = PW'(10); cfg_hblank_off = PW'(2);
        cfg_vf1_on = LW'(1); cfg_vf1_off = LW'(3);
        cfg_vf2_on = LW'(5); cfg_vf2_off = LW'(7);
        cfg_fld_lo = LW'(1); cfg_fld_hi = LW'(5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_idle("R8");                         // reset / disabled state

        en = 1'b1;
        cur = 0;
        for (int i = 0; i < 10; i++) begin
            int k;
            k = int'(VECS[i].frame) * W * HT + (int'(VECS[i].line) - 1) * W + int'(VECS[i].pix);
            go_to(k);
            chk("R1", "line", int'(line_cnt), int'(VECS[i].line));
            chk("R1", "pix", int'(pix_cnt), int'(VECS[i].pix));
            chk("R2", "h", int'(h_flag), int'(VECS[i].h));
            chk((VECS[i].line < 5) ? "R3" : "R4", "v", int'(v_flag), int'(VECS[i].v));
            chk("R5", "f", int'(f_flag), int'(VECS[i].f));
            chk("R6", "valid", int'(trs_valid), int'(VECS[i].val));
            chk((VECS[i].data[7] && VECS[i].data != 8'hFF) ? "R7 R10" : "R6", "data",
                int'(trs_data), int'(VECS[i].data));
        end

        // R8: drop enable while the status word is on the output
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_idle("R8");

        // R9: widen the line mid-frame; takes effect only after wrap
        en = 1'b1;
        cur = 0;
        go_to(20);
        cfg_pixels = PW'(20);
        go_to(32);
        chk("R9", "line", int'(line_cnt), 3);
        chk("R9", "pix", int'(pix_cnt), 0);
        go_to(W * HT);
        chk("R9", "line", int'(line_cnt), 1);
        chk("R9", "pix", int'(pix_cnt), 0);
        go_to(W * HT + 16);
        chk("R9", "line", int'(line_cnt), 1);
        chk("R9", "pix", int'(pix_cnt), 16);
        go_to(W * HT + 20);
        chk("R9", "line", int'(line_cnt), 2);
        chk("R9", "pix", int'(pix_cnt), 0);

        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_idle("R8");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_total++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

endmodule